// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block is the integer multiply and divide engine of a 32-bit RISC core. It takes an operation code, two operands and a one-cycle start strobe. Multiplies and divides run for a fixed number of cycles equal to the operand width, and a busy flag is held high for that whole time. Each result is written into a private pair of result registers, HI and LO, and not into the general register file. The core reads the pair through two read ports. It must hold off any read of HI or LO while busy is high. The unit itself keeps both registers frozen until the result is ready.

A multiply leaves the double-width product split across HI (upper half) and LO (lower half). A divide leaves the quotient in LO and the remainder in HI. Signed variants work on the magnitudes of the operands and correct the signs at the end, so the quotient rounds toward zero and the remainder follows the dividend's sign. Two move-to operations load HI or LO directly from operand A. If a move-to arrives while an operation is running, it is held and applied when that operation finishes, and it takes the place of that half of the result.

The operand width is a parameter, default 32. The cycle count, counter widths and datapath widths are all derived from it.

Top module: `hilo_arith_unit`

## Requirements
- R1: While reset is asserted and after it is released, busy_o is 0 and hi_o and lo_o are both 0.
- R2: Operation code 0 (signed multiply) treats both operands as two's complement and writes the upper half of the 2*WIDTH-bit product to hi_o and the lower half to lo_o.
- R3: Operation code 1 (unsigned multiply) treats both operands as unsigned and splits the product between hi_o and lo_o in the same way.
- R4: Operation code 2 (signed divide) writes a quotient truncated toward zero to lo_o and a remainder carrying the dividend's sign to hi_o. The most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R5: Operation code 3 (unsigned divide) writes the unsigned quotient to lo_o and the unsigned remainder to hi_o.
- R6: A start with codes 0 to 3 accepted while idle raises busy_o at the next clock. busy_o stays high for exactly WIDTH cycles. The result is visible on hi_o and lo_o in the cycle busy_o falls, and hi_o and lo_o do not change while busy_o is high.
- R7: A divide by zero, signed or unsigned, still drops busy_o after exactly WIDTH cycles. The values left in HI and LO are unspecified.
- R8: When idle, code 4 loads hi_o from opa_i and code 5 loads lo_o from opa_i at the next clock. busy_o stays low and the other register is unchanged.
- R9: A start with codes 0 to 3 while busy_o is high is ignored. The running operation finishes at its own time with its own result, and nothing is queued.
- R10: A start with code 4 or 5 while busy_o is high is held and applied at completion. The affected register then shows opa_i from the move, and the other register shows the arithmetic result.
- R11: Codes 6 and 7 have no effect on busy_o, hi_o or lo_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 3 | Operation code (0 smul, 1 umul, 2 sdiv, 3 udiv, 4 load HI, 5 load LO) |
| opa_i | input | WIDTH | Operand A: multiplicand, dividend, or move-to data |
| opb_i | input | WIDTH | Operand B: multiplier or divisor |
| busy_o | output | 1 | High while an operation is running |
| hi_o | output | WIDTH | HI register: product upper half or remainder |
| lo_o | output | WIDTH | LO register: product lower half or quotient |

## Verification
The bench uses a 4-bit configuration and sweeps every operand pair through all four arithmetic codes. This reaches the sign-correction corner cases:
- Negative-by-negative and mixed-sign products. A design that skipped the final negation would return the unsigned magnitude product.
- The most-negative-divided-by-minus-one case. A design that saturated it or trapped on it would not return the most negative quotient with a zero remainder.
- Remainders with a negative dividend. A design that floored the quotient instead of truncating would give a remainder with the wrong sign.
- Divide by zero. A design that hung on it would never drop busy.

Further directed cases target the timing rules:
- A second arithmetic start while busy must leave the first result intact and add no extra busy period.
- A move-to issued mid-operation must win over its half of the result rather than be lost or applied early.
- Illegal codes must leave both registers untouched.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  localparam logic [2:0] HOP_SMUL  = 3'd0;
  localparam logic [2:0] HOP_UMUL  = 3'd1;
  localparam logic [2:0] HOP_SDIV  = 3'd2;
  localparam logic [2:0] HOP_UDIV  = 3'd3;
  localparam logic [2:0] HOP_SETHI = 3'd4;
  localparam logic [2:0] HOP_SETLO = 3'd5;

  typedef enum logic {
    KIND_MUL = 1'b0,
    KIND_DIV = 1'b1
  } hilo_kind_e;

  function automatic logic op_is_arith(input logic [2:0] op);
    return (op == HOP_SMUL) || (op == HOP_UMUL) ||
           (op == HOP_SDIV) || (op == HOP_UDIV);
  endfunction

endpackage

// File: rtl/hilo_reset_sync.sv
module hilo_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/hilo_operand_prep.sv
module hilo_operand_prep
  import hilo_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] mag_a,
  output logic [WIDTH-1:0] mag_b,
  output hilo_kind_e       kind,
  output logic             neg_main,
  output logic             neg_rem
);

  logic is_signed;
  logic a_neg;
  logic b_neg;

  always_comb begin
    is_signed = (op == HOP_SMUL) || (op == HOP_SDIV);
    a_neg     = is_signed & opa[WIDTH-1];
    b_neg     = is_signed & opb[WIDTH-1];
    mag_a     = a_neg ? (~opa + 1'b1) : opa;
    mag_b     = b_neg ? (~opb + 1'b1) : opb;
    kind      = ((op == HOP_SDIV) || (op == HOP_UDIV)) ? KIND_DIV : KIND_MUL;
    // product and quotient follow both signs; remainder follows the dividend
    neg_main  = a_neg ^ b_neg;
    neg_rem   = a_neg;
  end

endmodule

// File: rtl/hilo_iter_step.sv
module hilo_iter_step
  import hilo_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  hilo_kind_e       kind,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] sh,
  input  logic [WIDTH-1:0] mcand,
  output logic [WIDTH-1:0] acc_nx,
  output logic [WIDTH-1:0] sh_nx
);

  logic [WIDTH:0]   add_sum;
  logic [WIDTH+1:0] trial;
  logic             borrow;

  always_comb begin
    // shift-add: add multiplicand when the current multiplier bit is set,
    // then shift the double-width {acc, sh} right by one
    add_sum = {1'b0, acc} + (sh[0] ? {1'b0, mcand} : '0);
    // restoring shift-subtract: bring in next dividend bit, try subtract
    trial   = {1'b0, acc, sh[WIDTH-1]} - {2'b00, mcand};
    borrow  = trial[WIDTH+1];
    if (kind == KIND_MUL) begin
      acc_nx = add_sum[WIDTH:1];
      sh_nx  = {add_sum[0], sh[WIDTH-1:1]};
    end else begin
      acc_nx = borrow ? {acc[WIDTH-2:0], sh[WIDTH-1]} : trial[WIDTH-1:0];
      sh_nx  = {sh[WIDTH-2:0], ~borrow};
    end
  end

endmodule

// File: rtl/hilo_result_fix.sv
module hilo_result_fix
  import hilo_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  hilo_kind_e       kind,
  input  logic             neg_main,
  input  logic             neg_rem,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] sh,
  output logic [WIDTH-1:0] hi_res,
  output logic [WIDTH-1:0] lo_res
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    prod;
  logic [PW-1:0]    prod_f;
  logic [WIDTH-1:0] quot_f;
  logic [WIDTH-1:0] rem_f;

  always_comb begin
    prod   = {acc, sh};
    prod_f = neg_main ? (~prod + 1'b1) : prod;
    quot_f = neg_main ? (~sh + 1'b1) : sh;
    rem_f  = neg_rem ? (~acc + 1'b1) : acc;
    if (kind == KIND_DIV) begin
      hi_res = rem_f;
      lo_res = quot_f;
    end else begin
      hi_res = prod_f[PW-1:WIDTH];
      lo_res = prod_f[WIDTH-1:0];
    end
  end

endmodule

// File: rtl/hilo_arith_unit.sv
module hilo_arith_unit
  import hilo_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

  logic rst_int_n;

  // state registers
  logic             busy_q,   busy_n;
  logic [CW-1:0]    cnt_q,    cnt_n;
  logic [WIDTH-1:0] acc_q,    acc_n;
  logic [WIDTH-1:0] sh_q,     sh_n;
  logic [WIDTH-1:0] mcand_q,  mcand_n;
  hilo_kind_e       kind_q,   kind_n;
  logic             negm_q,   negm_n;
  logic             negr_q,   negr_n;
  logic [WIDTH-1:0] hi_q,     hi_n;
  logic [WIDTH-1:0] lo_q,     lo_n;
  logic             phv_q,    phv_n;
  logic [WIDTH-1:0] phd_q,    phd_n;
  logic             plv_q,    plv_n;
  logic [WIDTH-1:0] pld_q,    pld_n;

  // datapath wires
  logic [WIDTH-1:0] mag_a, mag_b;
  hilo_kind_e       prep_kind;
  logic             prep_negm, prep_negr;
  logic [WIDTH-1:0] step_acc, step_sh;
  logic [WIDTH-1:0] res_hi, res_lo;

  // request decode
  logic accept_arith;
  logic move_hi, move_lo;
  logic finishing;
  logic en_state;

  hilo_reset_sync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  hilo_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op       (op_i),
    .opa      (opa_i),
    .opb      (opb_i),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .kind     (prep_kind),
    .neg_main (prep_negm),
    .neg_rem  (prep_negr)
  );

  hilo_iter_step #(.WIDTH(WIDTH)) u_step (
    .kind   (kind_q),
    .acc    (acc_q),
    .sh     (sh_q),
    .mcand  (mcand_q),
    .acc_nx (step_acc),
    .sh_nx  (step_sh)
  );

  hilo_result_fix #(.WIDTH(WIDTH)) u_fix (
    .kind     (kind_q),
    .neg_main (negm_q),
    .neg_rem  (negr_q),
    .acc      (step_acc),
    .sh       (step_sh),
    .hi_res   (res_hi),
    .lo_res   (res_lo)
  );

  always_comb begin
    accept_arith = start_i && !busy_q && op_is_arith(op_i);
    move_hi      = start_i && (op_i == HOP_SETHI);
    move_lo      = start_i && (op_i == HOP_SETLO);
    finishing    = busy_q && (cnt_q == LAST_CNT);
    en_state     = accept_arith || busy_q || move_hi || move_lo;

    busy_n  = busy_q;
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    sh_n    = sh_q;
    mcand_n = mcand_q;
    kind_n  = kind_q;
    negm_n  = negm_q;
    negr_n  = negr_q;
    hi_n    = hi_q;
    lo_n    = lo_q;
    phv_n   = phv_q;
    phd_n   = phd_q;
    plv_n   = plv_q;
    pld_n   = pld_q;

    if (accept_arith) begin
      busy_n  = 1'b1;
      cnt_n   = '0;
      acc_n   = '0;
      sh_n    = mag_a;
      mcand_n = mag_b;
      kind_n  = prep_kind;
      negm_n  = prep_negm;
      negr_n  = prep_negr;
    end else if (busy_q) begin
      acc_n = step_acc;
      sh_n  = step_sh;
      cnt_n = cnt_q + 1'b1;
      if (move_hi) begin
        phv_n = 1'b1;
        phd_n = opa_i;
      end
      if (move_lo) begin
        plv_n = 1'b1;
        pld_n = opa_i;
      end
      if (finishing) begin
        busy_n = 1'b0;
        // newest move wins, then a held move, then the arithmetic result
        hi_n   = move_hi ? opa_i : (phv_q ? phd_q : res_hi);
        lo_n   = move_lo ? opa_i : (plv_q ? pld_q : res_lo);
        phv_n  = 1'b0;
        plv_n  = 1'b0;
      end
    end else begin
      if (move_hi) hi_n = opa_i;
      if (move_lo) lo_n = opa_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      acc_q   <= '0;
      sh_q    <= '0;
      mcand_q <= '0;
      kind_q  <= KIND_MUL;
      negm_q  <= 1'b0;
      negr_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      phv_q   <= 1'b0;
      phd_q   <= '0;
      plv_q   <= 1'b0;
      pld_q   <= '0;
    end else if (en_state) begin
      busy_q  <= busy_n;
      cnt_q   <= cnt_n;
      acc_q   <= acc_n;
      sh_q    <= sh_n;
      mcand_q <= mcand_n;
      kind_q  <= kind_n;
      negm_q  <= negm_n;
      negr_q  <= negr_n;
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      phv_q   <= phv_n;
      phd_q   <= phd_n;
      plv_q   <= plv_n;
      pld_q   <= pld_n;
    end
  end

  assign busy_o = busy_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

endmodule

// File: rtl/hilo_arith_unit_chk.sv
module hilo_arith_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] opa_i,
  input logic             busy_o,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o
);

  localparam int RW = $clog2(WIDTH + 1) + 1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= busy_o ? run_q + 1'b1 : '0;
    end
  end

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && int'(run_q) < WIDTH - 1) |=> busy_o);

  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && int'(run_q) == WIDTH - 1) |=> !busy_o);

  p_hilo_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || ($stable(hi_o) && $stable(lo_o))));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && op_i <= 3'd3) |=> busy_o);

  p_move_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && op_i == 3'd4) |=> (!busy_o && hi_o == $past(opa_i) && $stable(lo_o)));

  p_move_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && op_i == 3'd5) |=> (!busy_o && lo_o == $past(opa_i) && $stable(hi_o)));

  p_bad_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && op_i >= 3'd6) |=> (!busy_o && $stable(hi_o) && $stable(lo_o)));

endmodule

bind hilo_arith_unit hilo_arith_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .op_i    (op_i),
  .opa_i   (opa_i),
  .busy_o  (busy_o),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/hilo_arith_unit_test.sv
module hilo_arith_unit_test;

  localparam int BW   = 4;
  localparam int HALF = 1 << (BW - 1);
  localparam int FULL = 1 << BW;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [2:0]    op_i;
  logic [BW-1:0] opa_i;
  logic [BW-1:0] opb_i;
  logic          busy_o;
  logic [BW-1:0] hi_o;
  logic [BW-1:0] lo_o;

  int n_chk;
  int n_err;

  hilo_arith_unit #(.WIDTH(BW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .busy_o  (busy_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= HALF) ? v - FULL : v;
  endfunction

  task automatic issue(input logic [2:0] op, input int a, input int b);
    @(negedge clk);
    op_i    = op;
    opa_i   = a[BW-1:0];
    opb_i   = b[BW-1:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(150000 * 20);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    int eh;
    int el;
    n_chk   = 0;
    n_err   = 0;
    rst_n   = 1'b0;
    start_i = 1'b0;
    op_i    = 3'd0;
    opa_i   = '0;
    opb_i   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 hi", int'(hi_o), 0);
    chk("R1 lo", int'(lo_o), 0);

    // exhaustive sweep: R2 R3 R4 R5 R6 R7
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < FULL; a++) begin
        for (int b = 0; b < FULL; b++) begin
          int p;
          issue(3'(op), a, b);
          wait_idle(cyc);
          if ((op == 2 || op == 3) && b == 0) begin
            chk("R7 div0 busy cycles", cyc, BW);
          end else begin
            chk("R6 busy cycles", cyc, BW);
            case (op)
              0: begin
                p  = (sx(a) * sx(b)) & (FULL * FULL - 1);
                chk("R2 smul hi", int'(hi_o), p >> BW);
                chk("R2 smul lo", int'(lo_o), p & (FULL - 1));
              end
              1: begin
                p  = a * b;
                chk("R3 umul hi", int'(hi_o), p >> BW);
                chk("R3 umul lo", int'(lo_o), p & (FULL - 1));
              end
              2: begin
                eh = (sx(a) % sx(b)) & (FULL - 1);
                el = (sx(a) / sx(b)) & (FULL - 1);
                chk("R4 sdiv rem", int'(hi_o), eh);
                chk("R4 sdiv quot", int'(lo_o), el);
              end
              default: begin
                chk("R5 udiv rem", int'(hi_o), a % b);
                chk("R5 udiv quot", int'(lo_o), a / b);
              end
            endcase
          end
        end
      end
    end

    // R4 most negative over minus one, stated explicitly
    issue(3'd2, HALF, FULL - 1);
    wait_idle(cyc);
    chk("R4 min/-1 quot", int'(lo_o), HALF);
    chk("R4 min/-1 rem", int'(hi_o), 0);

    // R9 arithmetic start while busy is ignored
    issue(3'd1, 3, 5);
    chk("R9 busy after start", int'(busy_o), 1);
    @(negedge clk);
    op_i = 3'd3; opa_i = 4'd9; opb_i = 4'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle(cyc);
    chk("R9 total busy cycles", cyc + 2, BW);
    chk("R9 hi kept", int'(hi_o), 0);
    chk("R9 lo kept", int'(lo_o), 15);
    repeat (3) @(negedge clk);
    chk("R9 no queued op", int'(busy_o), 0);

    // R10 move-to during busy applied at completion
    issue(3'd1, 7, 7);
    @(negedge clk);
    op_i = 3'd4; opa_i = 4'hA; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 hi frozen while busy", int'(hi_o), 0);
    wait_idle(cyc);
    chk("R10 hi from move", int'(hi_o), 10);
    chk("R10 lo from product", int'(lo_o), 1);

    // R8 idle moves
    issue(3'd5, 6, 0);
    chk("R8 lo loaded", int'(lo_o), 6);
    chk("R8 hi untouched", int'(hi_o), 10);
    chk("R8 busy low", int'(busy_o), 0);
    issue(3'd4, 13, 0);
    chk("R8 hi loaded", int'(hi_o), 13);
    chk("R8 lo untouched", int'(lo_o), 6);

    // R11 unused codes
    issue(3'd6, 15, 15);
    chk("R11 code6 hi", int'(hi_o), 13);
    chk("R11 code6 lo", int'(lo_o), 6);
    chk("R11 code6 busy", int'(busy_o), 0);
    issue(3'd7, 1, 1);
    chk("R11 code7 hi", int'(hi_o), 13);
    chk("R11 code7 lo", int'(lo_o), 6);
    chk("R11 code7 busy", int'(busy_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule